// File: doc/BRIEF.md
# I2C Master Bit and Byte Engine with Programmable Phase Timing

This block is a single-master I2C engine. Its clock is nominally 62.5 MHz, and every duration it produces is a whole number of those cycles. Software hands it one command at a time: a START, a STOP, a byte write or a byte read. The START command becomes a repeated START on its own when a transfer is already open, which means SCL is being held low. The engine drives SCL and SDA through active-high pull-low enables and never drives either line high. It samples SDA through a single input. At the end of each command it returns the byte it saw on the bus and the acknowledge level.

Four timing fields set the bus phase lengths, and each length is a fixed offset formula on those fields:

| Phase | Length in cycles |
|---|---|
| SCL high | high field + 5 |
| SCL low | low field + 2 |
| Data hold after SCL falls | low field / 2 + 1 |
| START setup and START hold | start field + 1 |
| Idle gap after STOP | high field / 2 + free field + 2 |

Two settings are typical:
- A high field of 308 and a low field of 310 give a 625-cycle bit, which is 100 kHz at 62.5 MHz.
- Smaller values reach 400 kHz.

The fields are captured when a command is accepted.

The block has no arbitration and does not honour clock stretching by slaves.

Top module: `i2c_phase_master`

## Requirements
- R1: After reset, `scl_pull`, `sda_pull`, `busy` and `done` are all 0.
- R2: During a data or acknowledge bit, `scl_pull` stays 1 for exactly low+2 cycles.
- R3: During a data or acknowledge bit, `scl_pull` stays 0 for exactly high+5 cycles. SDA is sampled on the last cycle of that high phase.
- R4: The new SDA level of a bit appears low/2+1 cycles after SCL was pulled low. It then stays unchanged until SCL is pulled low again.
- R5: A START is issued with `cmd_op`=0.
  - If SCL is low, SDA is first released at the low-phase midpoint, and SCL is released at the end of the low phase.
  - SCL and SDA are then both released for start+1 cycles.
  - SDA is then pulled for start+1 cycles before SCL is pulled.
- R6: A STOP is issued with `cmd_op`=1.
  - If SCL is low, SDA is pulled at the low-phase midpoint, and SCL is released at the end of the low phase.
  - SCL is then released for high+5 cycles before SDA is released.
- R7: After the STOP releases SDA, both lines stay released and `busy` stays 1 for high/2+free+2 cycles.
- R8: A write is issued with `cmd_op`=2.
  - Eight bits go out MSB first, and `sda_pull` is the inverse of each bit.
  - SDA is released on the ninth bit.
  - `rx_nack` reports the SDA level sampled on the ninth bit.
  - `rd_data` reports the eight bits sampled on the bus.
- R9: A read is issued with `cmd_op`=3.
  - SDA is released for eight bits, and `rd_data` holds the sampled levels MSB first.
  - On the ninth bit, `sda_pull` is 1 when `cmd_nack`=0 and 0 when `cmd_nack`=1.
  - `rx_nack` reports the SDA level sampled on the ninth bit.
- R10: Timing of `busy` and `done`:
  - A command is accepted when `cmd_valid`=1 while `busy`=0, and `busy` rises in the following cycle.
  - When the command completes, `busy` falls in the same cycle that `done` pulses high for exactly one cycle.
  - `cmd_valid` while `busy`=1 is ignored.
- R11: Changing any timing field while `busy`=1 has no effect on the command in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request; taken when idle |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| cmd_wdata | input | 8 | Byte to transmit |
| cmd_nack | input | 1 | Read: 1 sends NACK, 0 sends ACK |
| cfg_high | input | FIELD_W | SCL high field |
| cfg_low | input | FIELD_W | SCL low field |
| cfg_start | input | FIELD_W | START setup/hold field |
| cfg_free | input | FIELD_W | Extra idle-gap field |
| sda_in | input | 1 | Sampled SDA level |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte observed on the bus |
| rx_nack | output | 1 | SDA level on the ninth clock |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |

## Verification
The main function is exercised with several kinds of byte:
- Alternating patterns (0xA5, 0x5A, 0x3C, 0xC3) catch a swapped bit order, a lost inversion and an off-by-one shift.
- All-ones and all-zeros bytes show that the line is released when it should be and pulled when it should be.

The acknowledge cases are checked in both directions. The bench tries a slave ACK against a slave NACK on writes, and a master ACK against a master NACK on reads.

Three settings of the timing fields are used:
- An even low field.
- An odd low field together with zero start and free fields, which separates the half-period rounding from the plain offsets.
- The 100 kHz setting.

START is issued both from an idle bus and with SCL held low, so both branches of each line sequence are seen. STOP is issued the same two ways.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } i2cm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_SETUP,
    ST_HOLD,
    ST_FREE
  } i2cm_state_e;

  // Phase length formulas, in system clock cycles.
  function automatic int high_len(input int hp);
    return hp + 5;
  endfunction

  function automatic int low_len(input int lp);
    return lp + 2;
  endfunction

  function automatic int half_len(input int lp);
    return lp / 2 + 1;
  endfunction

  function automatic int start_len(input int sh);
    return sh + 1;
  endfunction

  function automatic int free_len(input int hp, input int bft);
    return hp / 2 + bft + 2;
  endfunction

endpackage

// File: rtl/i2cm_timing_latch.sv
`timescale 1ns/1ps
module i2cm_timing_latch
  import i2cm_pkg::*;
#(
  parameter int FIELD_W = 10,
  parameter int CNT_W   = FIELD_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FIELD_W-1:0] cfg_high,
  input  logic [FIELD_W-1:0] cfg_low,
  input  logic [FIELD_W-1:0] cfg_start,
  input  logic [FIELD_W-1:0] cfg_free,
  output logic [CNT_W-1:0]   len_high,
  output logic [CNT_W-1:0]   len_low,
  output logic [CNT_W-1:0]   len_half,
  output logic [CNT_W-1:0]   len_start,
  output logic [CNT_W-1:0]   len_free
);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_high  <= '0;
      len_low   <= '0;
      len_half  <= '0;
      len_start <= '0;
      len_free  <= '0;
    end else if (load) begin
      len_high  <= CNT_W'(high_len(int'(cfg_high)));
      len_low   <= CNT_W'(low_len(int'(cfg_low)));
      len_half  <= CNT_W'(half_len(int'(cfg_low)));
      len_start <= CNT_W'(start_len(int'(cfg_start)));
      len_free  <= CNT_W'(free_len(int'(cfg_high), int'(cfg_free)));
    end
  end

endmodule

// File: rtl/i2cm_phase_ctr.sv
`timescale 1ns/1ps
module i2cm_phase_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  assign last = (cnt == target - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (restart) cnt <= '0;
    else if (run)     cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/i2cm_shifter.sv
`timescale 1ns/1ps
module i2cm_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              ack_en,
  output logic [DATA_W-1:0] data,
  output logic              nack
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      nack <= 1'b0;
    end else begin
      if (load)          data <= load_val;
      else if (shift_en) data <= {data[DATA_W-2:0], bit_in};
      if (ack_en)        nack <= bit_in;
    end
  end

endmodule

// File: rtl/i2c_phase_master.sv
`timescale 1ns/1ps
module i2c_phase_master
  import i2cm_pkg::*;
#(
  parameter int FIELD_W = 10,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [DATA_W-1:0]  cmd_wdata,
  input  logic               cmd_nack,
  input  logic [FIELD_W-1:0] cfg_high,
  input  logic [FIELD_W-1:0] cfg_low,
  input  logic [FIELD_W-1:0] cfg_start,
  input  logic [FIELD_W-1:0] cfg_free,
  input  logic               sda_in,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rx_nack,
  output logic               scl_pull,
  output logic               sda_pull
);

  localparam int CNT_W = FIELD_W + 2;
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] ACK_IDX = BIT_W'(DATA_W);

  i2cm_state_e      state;
  i2cm_op_e         op_q;
  logic             nack_q;
  logic [BIT_W-1:0] bit_idx;

  logic [CNT_W-1:0] len_high, len_low, len_half, len_start, len_free;
  logic [CNT_W-1:0] target, cnt;
  logic             last;

  // Named internal events.
  wire accept     = cmd_valid && (state == ST_IDLE);
  wire phase_end  = busy && last;
  wire mid_hit    = (state == ST_LOW) && (cnt == len_half - CNT_W'(1));
  wire data_op    = (op_q == OP_WRITE) || (op_q == OP_READ);
  wire ack_slot   = (bit_idx == ACK_IDX);
  wire sample_hit = (state == ST_HIGH) && phase_end && data_op;
  wire data_high  = (state == ST_HIGH) && data_op;
  logic mid_pull;

  assign busy = (state != ST_IDLE);

  i2cm_timing_latch #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_timing (
    .clk(clk), .rst(rst), .load(accept),
    .cfg_high(cfg_high), .cfg_low(cfg_low), .cfg_start(cfg_start), .cfg_free(cfg_free),
    .len_high(len_high), .len_low(len_low), .len_half(len_half),
    .len_start(len_start), .len_free(len_free)
  );

  always_comb begin
    case (state)
      ST_HIGH:           target = len_high;
      ST_SETUP, ST_HOLD: target = len_start;
      ST_FREE:           target = len_free;
      default:           target = len_low;
    endcase
  end

  i2cm_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .run(busy), .restart(accept || phase_end),
    .target(target), .cnt(cnt), .last(last)
  );

  i2cm_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(accept), .load_val(cmd_wdata),
    .shift_en(sample_hit && !ack_slot), .bit_in(sda_in),
    .ack_en(sample_hit && ack_slot), .data(rd_data), .nack(rx_nack)
  );

  always_comb begin
    case (op_q)
      OP_START: mid_pull = 1'b0;
      OP_STOP:  mid_pull = 1'b1;
      OP_WRITE: mid_pull = ack_slot ? 1'b0 : ~rd_data[DATA_W-1];
      default:  mid_pull = ack_slot ? ~nack_q : 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_q     <= OP_START;
      nack_q   <= 1'b0;
      bit_idx  <= '0;
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_valid) begin
          op_q    <= i2cm_op_e'(cmd_op);
          nack_q  <= cmd_nack;
          bit_idx <= '0;
          case (i2cm_op_e'(cmd_op))
            OP_START: state <= scl_pull ? ST_LOW : ST_SETUP;
            OP_STOP:  state <= scl_pull ? ST_LOW : ST_HIGH;
            default: begin
              scl_pull <= 1'b1;
              state    <= ST_LOW;
            end
          endcase
        end
        ST_LOW: begin
          if (mid_hit) sda_pull <= mid_pull;
          if (phase_end) begin
            scl_pull <= 1'b0;
            state    <= (op_q == OP_START) ? ST_SETUP : ST_HIGH;
          end
        end
        ST_HIGH: if (phase_end) begin
          if (op_q == OP_STOP) begin
            sda_pull <= 1'b0;
            state    <= ST_FREE;
          end else begin
            scl_pull <= 1'b1;
            if (ack_slot) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              bit_idx <= bit_idx + BIT_W'(1);
              state   <= ST_LOW;
            end
          end
        end
        ST_SETUP: if (phase_end) begin
          sda_pull <= 1'b1;
          state    <= ST_HOLD;
        end
        ST_HOLD: if (phase_end) begin
          scl_pull <= 1'b1;
          state    <= ST_IDLE;
          done     <= 1'b1;
        end
        ST_FREE: if (phase_end) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Assertions next to the logic they guard.
  assert_low_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOW) |-> (cnt < len_low) && scl_pull);

  assert_high_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HIGH) |-> (cnt < len_high) && !scl_pull);

  assert_data_stable_high_R4: assert property (@(posedge clk) disable iff (rst)
    (data_high && $past(data_high)) |-> $stable(sda_pull));

  assert_start_order_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |-> (!scl_pull && sda_pull));

  assert_stop_release_R6: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_HIGH) && (op_q == OP_STOP) && $past(state == ST_LOW)) |-> sda_pull);

  assert_free_released_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FREE) |-> (!scl_pull && !sda_pull));

  assert_write_ack_release_R8: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_HIGH) && (op_q == OP_WRITE) && ack_slot) |-> !sda_pull);

  assert_read_release_R9: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_HIGH) && (op_q == OP_READ) && !ack_slot) |-> !sda_pull);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_falls_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_fields_latched_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(len_high) && $stable(len_low) &&
                               $stable(len_start) && $stable(len_free)));

endmodule

// File: tb/tb_i2c_phase_master.sv
`timescale 1ns/1ps
module tb_i2c_phase_master;

  localparam int FW = 10;
  localparam logic [1:0] C_START = 2'd0, C_STOP = 2'd1, C_WRITE = 2'd2, C_READ = 2'd3;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_nack = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_wdata = 8'h00;
  logic [FW-1:0] cfg_high = 10'd6, cfg_low = 10'd8, cfg_start = 10'd3, cfg_free = 10'd4;
  logic sda_in, busy, done, rx_nack, scl_pull, sda_pull;
  logic [7:0] rd_data;
  logic slave_pull = 1'b0;

  always #5 clk = ~clk;
  assign sda_in = ~(sda_pull | slave_pull);

  i2c_phase_master #(.FIELD_W(FW), .DATA_W(8)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack), .cfg_high(cfg_high),
    .cfg_low(cfg_low), .cfg_start(cfg_start), .cfg_free(cfg_free),
    .sda_in(sda_in), .busy(busy), .done(done), .rd_data(rd_data),
    .rx_nack(rx_nack), .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  typedef struct packed {
    logic       scl;
    logic       sda;
    logic       bsy;
    logic       dn;
    logic [3:0] tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0, cycle = 0;
  logic finished = 1'b0;
  logic m_scl = 1'b0, m_sda = 1'b0;
  logic data_chk = 1'b0;
  logic [3:0] data_tag = 4'd8, tag_ovr = 4'd0;
  logic [7:0] exp_rd = 8'h00;
  logic exp_nack = 1'b0;
  logic [8:0] s_bits = '0;
  int r = 9;
  logic last_scl_s = 1'b0;

  function automatic string rname(input logic [3:0] t);
    case (t)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic push(input int n, input logic scl, input logic sda,
                      input logic bsy, input logic dn, input logic [3:0] t);
    for (int i = 0; i < n; i++)
      q.push_back('{scl, sda, bsy, dn, (tag_ovr != 0) ? tag_ovr : t});
  endtask

  // Slave: changes its SDA pull only right after SCL is pulled low.
  always @(posedge clk) begin
    #3;
    if (!last_scl_s && scl_pull) r++;
    last_scl_s = scl_pull;
    slave_pull = (r < 9) ? s_bits[r] : 1'b0;
  end

  // Cycle-by-cycle comparison against the reference queue.
  always @(posedge clk) begin
    exp_t e;
    #2;
    cycle++;
    if (!rst && !finished) begin
      if (q.size() > 0) e = q.pop_front();
      else e = '{m_scl, m_sda, 1'b0, 1'b0, 4'd10};
      checks++;
      if ({scl_pull, sda_pull, busy, done} !== {e.scl, e.sda, e.bsy, e.dn}) begin
        fails++;
        $display("FAIL %s cycle %0d scl/sda/busy/done got %b%b%b%b exp %b%b%b%b",
                 rname(e.tag), cycle, scl_pull, sda_pull, busy, done,
                 e.scl, e.sda, e.bsy, e.dn);
      end
      if (e.dn && data_chk) begin
        checks += 2;
        if (rd_data !== exp_rd) begin
          fails++;
          $display("FAIL %s rd_data got %h exp %h", rname(data_tag), rd_data, exp_rd);
        end
        if (rx_nack !== exp_nack) begin
          fails++;
          $display("FAIL %s rx_nack got %b exp %b", rname(data_tag), rx_nack, exp_nack);
        end
      end
    end
  end

  // Builds the expected line waveform of one command and drives it.
  task automatic issue(input logic [1:0] op, input logic [7:0] wd, input logic nk,
                       input logic [7:0] sbyte, input logic sack);
    int hi, lo, hf, st, fr;
    @(negedge clk);
    while (q.size() != 0) @(negedge clk);
    hi = int'(cfg_high) + 5;
    lo = int'(cfg_low) + 2;
    hf = int'(cfg_low) / 2 + 1;
    st = int'(cfg_start) + 1;
    fr = int'(cfg_high) / 2 + int'(cfg_free) + 2;
    s_bits = '0;
    data_chk = 1'b0;
    if (op == C_WRITE || op == C_READ) begin
      data_chk = 1'b1;
      for (int b = 0; b < 9; b++) begin
        logic p;
        if (op == C_WRITE) p = (b < 8) ? ~wd[7-b] : 1'b0;
        else               p = (b < 8) ? 1'b0 : ~nk;
        push(hf, 1'b1, m_sda, 1'b1, 1'b0, 4'd4);
        m_sda = p;
        push(lo - hf, 1'b1, p, 1'b1, 1'b0, (op == C_WRITE) ? 4'd2 : 4'd9);
        push(hi, 1'b0, p, 1'b1, 1'b0, 4'd3);
        m_scl = 1'b1;
      end
      push(1, 1'b1, m_sda, 1'b0, 1'b1, 4'd10);
      if (op == C_WRITE) begin
        s_bits[8] = sack;
        exp_rd = wd;
        exp_nack = ~sack;
        data_tag = 4'd8;
      end else begin
        for (int b = 0; b < 8; b++) s_bits[b] = ~sbyte[7-b];
        exp_rd = sbyte;
        exp_nack = nk;
        data_tag = 4'd9;
      end
    end else if (op == C_START) begin
      if (m_scl) begin
        push(hf, 1'b1, m_sda, 1'b1, 1'b0, 4'd5);
        m_sda = 1'b0;
        push(lo - hf, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5);
      end
      push(st, 1'b0, m_sda, 1'b1, 1'b0, 4'd5);
      m_sda = 1'b1;
      push(st, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5);
      m_scl = 1'b1;
      push(1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd10);
    end else begin
      if (m_scl) begin
        push(hf, 1'b1, m_sda, 1'b1, 1'b0, 4'd6);
        m_sda = 1'b1;
        push(lo - hf, 1'b1, 1'b1, 1'b1, 1'b0, 4'd6);
      end
      push(hi, 1'b0, m_sda, 1'b1, 1'b0, 4'd6);
      m_sda = 1'b0;
      m_scl = 1'b0;
      push(fr, 1'b0, 1'b0, 1'b1, 1'b0, 4'd7);
      push(1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10);
    end
    r = 0;
    last_scl_s = 1'b1;
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_wdata = wd;
    cmd_nack = nk;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_cfg(input int h, input int l, input int s, input int f);
    cfg_high = FW'(h);
    cfg_low = FW'(l);
    cfg_start = FW'(s);
    cfg_free = FW'(f);
  endtask

  task automatic summary;
    finished = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;  // R1 reset state
    if ({scl_pull, sda_pull, busy, done} !== 4'b0000) begin
      fails++;
      $display("FAIL R1 reset outputs got %b%b%b%b exp 0000", scl_pull, sda_pull, busy, done);
    end
    // Even low field: START from idle, write, read, repeated START.
    issue(C_START, 8'h00, 1'b0, 8'h00, 1'b0);
    issue(C_WRITE, 8'hA5, 1'b0, 8'h00, 1'b1);
    issue(C_READ,  8'h00, 1'b0, 8'h3C, 1'b0);
    issue(C_START, 8'h00, 1'b0, 8'h00, 1'b0);
    issue(C_WRITE, 8'h5A, 1'b0, 8'h00, 1'b0);
    issue(C_READ,  8'h00, 1'b1, 8'hC3, 1'b0);
    issue(C_STOP,  8'h00, 1'b0, 8'h00, 1'b0);
    // Odd low field, zero start/free fields.
    set_cfg(3, 7, 0, 0);
    issue(C_START, 8'h00, 1'b0, 8'h00, 1'b0);
    tag_ovr = 4'd11;  // R11: fields change mid-command
    issue(C_WRITE, 8'hFF, 1'b0, 8'h00, 1'b1);
    repeat (20) @(negedge clk);
    set_cfg(40, 50, 9, 9);
    cmd_valid = 1'b1;  // R10: ignored while busy
    cmd_op = C_STOP;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    tag_ovr = 4'd0;
    set_cfg(3, 7, 0, 0);
    issue(C_READ, 8'h00, 1'b1, 8'h00, 1'b0);
    issue(C_STOP, 8'h00, 1'b0, 8'h00, 1'b0);
    issue(C_STOP, 8'h00, 1'b0, 8'h00, 1'b0);  // R6 from an idle bus
    // 100 kHz at 62.5 MHz: 313 + 312 = 625 cycles per bit.
    set_cfg(308, 310, 249, 300);
    issue(C_START, 8'h00, 1'b0, 8'h00, 1'b0);
    issue(C_WRITE, 8'h81, 1'b0, 8'h00, 1'b1);
    issue(C_STOP,  8'h00, 1'b0, 8'h00, 1'b0);
    @(negedge clk);
    while (q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired got busy=%b exp completion", busy);
      summary();
    end
  end

endmodule